// File: doc/BRIEF.md
# Coherence snoop conflict controller

This per-thread controller sits between the coherence network and the thread's two address-set signatures: one for the transaction's reads and one for its writes. Each incoming snoop is either shared or exclusive. A software-written configuration register decides which signature the snoop address is looked up in. A lookup that is enabled and hits does one of two things. It may raise a user-level conflict exception that names the signature and the request type. For write-set hits it may instead be answered with a negative acknowledgement (nack), which holds off the requester while a validated transaction copies its buffered writes out. When the conflict exception fires, lookups switch themselves off so the handler is not entered again and again. Software turns them back on by rewriting the register.

Software uses the register in phases. While a transaction runs, only exclusive snoops are checked against the read set. At commit start, write-set lookups are added for both request types. Once the transaction is validated, the read-set lookup is dropped and write-set hits are nacked. After the write copy is done, nack mode is cleared. The controller also watches the replies to the thread's own exclusive fetches. If a fetch keeps being nacked past a programmable number of cycles, the controller raises a separate retry exception. Finally, it flags local accesses that the sibling threads of the same core must check against their own signatures.

Top module: `snoop_conflict_ctrl`

## Requirements
- R1: After reset, `cfg_q` is 0 and `rsp_valid`, `exc_valid` and `xchk_valid` are all 0.
- R2: `cfg_q` holds five control bits:
  - bit 0 enables the shared-snoop lookup in the read set;
  - bit 1 enables the exclusive-snoop lookup in the read set;
  - bit 2 enables the shared-snoop lookup in the write set;
  - bit 3 enables the exclusive-snoop lookup in the write set;
  - bit 4 selects nack mode for write-set hits.

  A signature hit is ignored unless its pairing bit is set.
- R3: A snoop presented in cycle c gets exactly one response, with `rsp_valid` high in cycle c+2. `rsp_code` is 0 (no hit) when no enabled lookup hits.
- R4: An enabled read-set hit answers `rsp_code` 1 (ack). In the response cycle it also pulses `exc_valid`, with `exc_cause` 0 for a shared snoop and 1 for an exclusive snoop.
- R5: An enabled write-set hit with bit 4 clear answers ack and raises `exc_cause` 2 (shared) or 3 (exclusive). With bit 4 set, it answers `rsp_code` 2 (nack) for either request type and raises no exception.
- R6: A conflict exception clears `cfg_q` bits 3:0 and keeps bit 4. A snoop that follows, even back to back, then finds no lookup enabled.
- R7: A read-set conflict is reported ahead of a write-set conflict on the same snoop. A conflict is reported ahead of a retry timeout that falls in the same cycle. The timeout is not lost: it is reported in the next free cycle.
- R8: A nack reply to the thread's own exclusive fetch (`fx_rsp_valid`=1, `fx_rsp_nack`=1) starts a timeout. If no non-nack reply arrives, `exc_valid` pulses with `exc_cause` 4 `tmo_limit`+1 cycles after the edge that sampled the nack. A non-nack reply cancels the timeout. A `tmo_limit` of 0 disables it.
- R9: `xchk_valid` is raised one cycle after a local access to a line held modified or exclusive, when either of these holds:
  - the access is a store;
  - `any_copy` is high.

  `xchk_excl` is raised together with it and equals the store flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration write data |
| cfg_q | output | 5 | Current configuration |
| snp_valid | input | 1 | Incoming snoop present |
| snp_excl | input | 1 | Snoop is exclusive (1) or shared (0) |
| snp_addr | input | ADDR_W | Snoop line address |
| lk_addr | output | ADDR_W | Address presented to both signatures |
| rs_lk | output | 1 | Read-set lookup strobe |
| ws_lk | output | 1 | Write-set lookup strobe |
| rs_hit | input | 1 | Read-set signature hit for `lk_addr` |
| ws_hit | input | 1 | Write-set signature hit for `lk_addr` |
| rsp_valid | output | 1 | Snoop response present |
| rsp_code | output | 2 | 0 no hit, 1 ack, 2 nack |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 3 | 0..3 conflict cause, 4 retry timeout |
| fx_rsp_valid | input | 1 | Reply to own exclusive fetch |
| fx_rsp_nack | input | 1 | That reply is a nack |
| tmo_limit | input | TMO_W | Nack timeout in cycles, 0 disables |
| loc_valid | input | 1 | Local access present |
| loc_store | input | 1 | Local access is a store |
| loc_me | input | 1 | Line is held modified or exclusive |
| any_copy | input | 1 | Some thread is in its write copy phase |
| xchk_valid | output | 1 | Sibling threads must check this access |
| xchk_excl | output | 1 | Sibling check is of exclusive type |

## Verification
The bench builds the block with `ADDR_W`=8 and `TMO_W`=4. The short address lets a 16-entry bit model stand in for each signature. The 4-bit timeout lets the largest limit, 15, be reached within a few dozen cycles and checked for exact timing at the top of the counter range. Scoreboarded snoops cover the following cases:
- every lookup pairing;
- both nack settings;
- self-disable between back-to-back snoops;
- a timeout forced to coincide with a conflict.

// File: rtl/snp_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the snoop conflict controller.
// Assumes: cfg bit order is fixed, software and bench rely on it.
package snp_pkg;
    localparam int CFG_W    = 5;
    localparam int EN_W     = 4;   // lookup enable bits, index = 2*signature + excl
    localparam int NACK_BIT = 4;

    typedef enum logic [1:0] {
        RSP_NOHIT = 2'd0,
        RSP_ACK   = 2'd1,
        RSP_NACK  = 2'd2
    } rsp_e;

    typedef enum logic [2:0] {
        EXC_RS_SH = 3'd0,
        EXC_RS_EX = 3'd1,
        EXC_WS_SH = 3'd2,
        EXC_WS_EX = 3'd3,
        EXC_RETRY = 3'd4
    } exc_e;
endpackage

// File: rtl/snp_lookup_gate.sv
`timescale 1ns/1ps
// Registers the incoming snoop and gates the two signature lookups by the
// per-pairing enables. It then decides the reply and the conflict cause.
// Assumes: signature hits return combinationally in the cycle after capture.
module snp_lookup_gate
    import snp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic              snp_excl,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [CFG_W-1:0]  cfg,
    input  logic              rs_hit,
    input  logic              ws_hit,
    output logic [ADDR_W-1:0] lk_addr,
    output logic              rs_lk,
    output logic              ws_lk,
    output logic              s1_valid,
    output logic [1:0]        dec_code,
    output logic              conf_v,
    output logic [2:0]        conf_cause
);
    localparam int NSIG = 2;   // 0: read set, 1: write set

    logic              s1_excl;
    logic [ADDR_W-1:0] s1_addr;
    logic [NSIG-1:0]   lk, hit_in, conf;

    // Capture stage: hold the snoop for the lookup cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_excl  <= 1'b0;
            s1_addr  <= '0;
        end else begin
            s1_valid <= snp_valid;
            s1_excl  <= snp_excl;
            s1_addr  <= snp_addr;
        end
    end

    assign hit_in = {ws_hit, rs_hit};

    for (genvar g = 0; g < NSIG; g++) begin : g_sig
        assign lk[g]   = s1_valid & (s1_excl ? cfg[2*g+1] : cfg[2*g]);
        assign conf[g] = lk[g] & hit_in[g];
    end

    assign lk_addr = s1_addr;
    assign rs_lk   = lk[0];
    assign ws_lk   = lk[1];

    // Reply and exception-cause decision for the snoop in the lookup stage.
    always_comb begin
        dec_code   = RSP_NOHIT;
        conf_v     = 1'b0;
        conf_cause = EXC_RS_SH;
        if (conf[1] && cfg[NACK_BIT]) begin
            dec_code = RSP_NACK;
        end else if (|conf) begin
            dec_code = RSP_ACK;
        end
        if (conf[0]) begin
            conf_v     = 1'b1;
            conf_cause = s1_excl ? EXC_RS_EX : EXC_RS_SH;
        end else if (conf[1] && !cfg[NACK_BIT]) begin
            conf_v     = 1'b1;
            conf_cause = s1_excl ? EXC_WS_EX : EXC_WS_SH;
        end
    end
endmodule

// File: rtl/snp_nack_timer.sv
`timescale 1ns/1ps
// Watches replies to this thread's exclusive fetches. A nack starts a count,
// and reaching the limit emits a one-cycle fire pulse.
// Assumes: limit 0 means disabled; further nacks while counting do not restart.
module snp_nack_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fx_rsp_valid,
    input  logic             fx_rsp_nack,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             fire
);
    logic             armed;
    logic [TMO_W-1:0] cnt;

    // Arm on nack, count while armed, cancel on any non-nack reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (fx_rsp_valid && !fx_rsp_nack) begin
                armed <= 1'b0;
                cnt   <= '0;
            end else if (armed) begin
                if (cnt == TMO_W'(tmo_limit - 1'b1)) begin
                    fire  <= 1'b1;
                    armed <= 1'b0;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (fx_rsp_valid && fx_rsp_nack && tmo_limit != '0) begin
                armed <= 1'b1;
                cnt   <= '0;
            end
        end
    end
endmodule

// File: rtl/snp_exc_arb.sv
`timescale 1ns/1ps
// Orders exception sources: a snoop conflict wins and a retry timeout waits.
// Assumes: at most one conflict per cycle, already ordered by the gate.
module snp_exc_arb
    import snp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       conf_v,
    input  logic [2:0] conf_cause,
    input  logic       fire,
    output logic       exc_valid,
    output logic [2:0] exc_cause
);
    logic retry_pend;

    // Register one exception per cycle and hold any deferred timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_valid  <= 1'b0;
            exc_cause  <= EXC_RS_SH;
            retry_pend <= 1'b0;
        end else if (conf_v) begin
            exc_valid  <= 1'b1;
            exc_cause  <= conf_cause;
            retry_pend <= retry_pend | fire;
        end else if (fire || retry_pend) begin
            exc_valid  <= 1'b1;
            exc_cause  <= EXC_RETRY;
            retry_pend <= 1'b0;
        end else begin
            exc_valid  <= 1'b0;
        end
    end
endmodule

// File: rtl/snoop_conflict_ctrl.sv
`timescale 1ns/1ps
// Per-thread snoop conflict controller. It holds the lookup/nack configuration
// and answers each snoop two cycles after it arrives. It raises conflict and
// retry exceptions, and flags local accesses that sibling threads must check.
// Assumes: a software write in the same cycle as a conflict takes priority.
module snoop_conflict_ctrl
    import snp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_wdata,
    output logic [4:0]        cfg_q,
    input  logic              snp_valid,
    input  logic              snp_excl,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic [ADDR_W-1:0] lk_addr,
    output logic              rs_lk,
    output logic              ws_lk,
    input  logic              rs_hit,
    input  logic              ws_hit,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              exc_valid,
    output logic [2:0]        exc_cause,
    input  logic              fx_rsp_valid,
    input  logic              fx_rsp_nack,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              loc_valid,
    input  logic              loc_store,
    input  logic              loc_me,
    input  logic              any_copy,
    output logic              xchk_valid,
    output logic              xchk_excl
);
    logic       s1_valid, conf_v, fire;
    logic [1:0] dec_code;
    logic [2:0] conf_cause;

    // Configuration: software write, else self-disable of lookups on conflict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata;
        end else if (conf_v) begin
            cfg_q[EN_W-1:0] <= '0;
        end
    end

    // Response stage: one reply per captured snoop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_NOHIT;
        end else begin
            rsp_valid <= s1_valid;
            rsp_code  <= s1_valid ? dec_code : RSP_NOHIT;
        end
    end

    // Sibling cross-check request for local accesses to owned lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xchk_valid <= 1'b0;
            xchk_excl  <= 1'b0;
        end else begin
            xchk_valid <= loc_valid & loc_me & (loc_store | any_copy);
            xchk_excl  <= loc_valid & loc_me & loc_store;
        end
    end

    snp_lookup_gate #(.ADDR_W(ADDR_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .snp_valid  (snp_valid),
        .snp_excl   (snp_excl),
        .snp_addr   (snp_addr),
        .cfg        (cfg_q),
        .rs_hit     (rs_hit),
        .ws_hit     (ws_hit),
        .lk_addr    (lk_addr),
        .rs_lk      (rs_lk),
        .ws_lk      (ws_lk),
        .s1_valid   (s1_valid),
        .dec_code   (dec_code),
        .conf_v     (conf_v),
        .conf_cause (conf_cause)
    );

    snp_nack_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .fx_rsp_valid (fx_rsp_valid),
        .fx_rsp_nack  (fx_rsp_nack),
        .tmo_limit    (tmo_limit),
        .fire         (fire)
    );

    snp_exc_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .conf_v     (conf_v),
        .conf_cause (conf_cause),
        .fire       (fire),
        .exc_valid  (exc_valid),
        .exc_cause  (exc_cause)
    );
endmodule

// File: rtl/snp_conflict_chk.sv
`timescale 1ns/1ps
// Protocol checker for snoop_conflict_ctrl, attached by bind.
// Assumes: inputs are held low during reset.
module snp_conflict_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       snp_valid,
    input logic       rs_lk,
    input logic       ws_lk,
    input logic       rsp_valid,
    input logic [1:0] rsp_code,
    input logic       exc_valid,
    input logic [2:0] exc_cause,
    input logic       cfg_we,
    input logic [4:0] cfg_q,
    input logic       loc_valid,
    input logic       loc_me,
    input logic       xchk_valid
);
    p_rsp_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> ##1 rsp_valid);

    p_lookup_from_snoop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_lk || ws_lk) |-> $past(snp_valid));

    p_conflict_with_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_cause != 3'd4) |-> (rsp_valid && rsp_code == 2'd1));

    p_nack_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd2) |-> !(exc_valid && exc_cause inside {3'd2, 3'd3}));

    p_self_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_cause != 3'd4 && !$past(cfg_we)) |-> cfg_q[3:0] == 4'd0);

    p_xchk_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xchk_valid |-> $past(loc_valid && loc_me));
endmodule

bind snoop_conflict_ctrl snp_conflict_chk u_chk (.*);

// File: tb/sim_snoop_conflict_ctrl.sv
`timescale 1ns/1ps
module sim_snoop_conflict_ctrl;
    localparam int AW = 8;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_wdata = '0;
    logic [4:0]    cfg_q;
    logic          snp_valid = 1'b0, snp_excl = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic [AW-1:0] lk_addr;
    logic          rs_lk, ws_lk, rs_hit, ws_hit;
    logic          rsp_valid, exc_valid;
    logic [1:0]    rsp_code;
    logic [2:0]    exc_cause;
    logic          fx_rsp_valid = 1'b0, fx_rsp_nack = 1'b0;
    logic [TW-1:0] tmo_limit = 4'd3;
    logic          loc_valid = 1'b0, loc_store = 1'b0, loc_me = 1'b0, any_copy = 1'b0;
    logic          xchk_valid, xchk_excl;

    logic [15:0] rs_set = '0, ws_set = '0;   // signature models
    logic [4:0]  m_cfg = '0;                 // bench copy of the configuration

    typedef struct packed {
        logic [1:0] code;
        logic       ev;
        logic [2:0] cause;
    } exp_t;
    exp_t q[$];
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    assign rs_hit = rs_set[lk_addr[3:0]];
    assign ws_hit = ws_set[lk_addr[3:0]];

    snoop_conflict_ctrl #(.ADDR_W(AW), .TMO_W(TW)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: present one snoop at the current negedge and queue its expected reply.
    task automatic snoop(input logic [AW-1:0] a, input logic ex);
        exp_t e;
        logic rc, wc;
        rc = m_cfg[ex ? 1 : 0] & rs_set[a[3:0]];
        wc = m_cfg[ex ? 3 : 2] & ws_set[a[3:0]];
        e.code  = (wc && m_cfg[4]) ? 2'd2 : ((rc || wc) ? 2'd1 : 2'd0);
        e.ev    = rc | (wc & ~m_cfg[4]);
        e.cause = rc ? {2'b00, ex} : {2'b01, ex};
        if (e.ev) m_cfg[3:0] = 4'd0;
        q.push_back(e);
        snp_valid = 1'b1; snp_excl = ex; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic wcfg(input logic [4:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        m_cfg = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic loc(input logic st, input logic me, input logic cp,
                       input logic ev, input logic ee, input string req);
        loc_valid = 1'b1; loc_store = st; loc_me = me; any_copy = cp;
        @(negedge clk);
        loc_valid = 1'b0; loc_store = 1'b0; loc_me = 1'b0; any_copy = 1'b0;
        chk({req, " xchk_valid"}, 32'(xchk_valid), 32'(ev));
        chk({req, " xchk_excl"}, 32'(xchk_excl), 32'(ee));
    endtask

    // Timeout alone: nack sampled at edge E, expect retry exactly lim+1 cycles later.
    task automatic tmo_case(input logic [TW-1:0] lim, input logic expect_fire);
        tmo_limit = lim;
        fx_rsp_valid = 1'b1; fx_rsp_nack = 1'b1;
        @(negedge clk);
        fx_rsp_valid = 1'b0; fx_rsp_nack = 1'b0;
        for (int i = 1; i <= int'(lim) + 2; i++) begin
            @(negedge clk);
            if (expect_fire && i == int'(lim) + 1) begin
                chk("R8 retry exception", 32'(exc_valid), 1);
                chk("R8 retry cause", 32'(exc_cause), 4);
            end else begin
                chk("R8 no early/late exception", 32'(exc_valid), 0);
            end
        end
    endtask

    // Monitor: compare every response against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                chk("R3 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R3/R4/R5 rsp_code", 32'(rsp_code), 32'(e.code));
                chk("R4/R5/R7 exc_valid", 32'(exc_valid), 32'(e.ev));
                if (e.ev) chk("R4/R5/R7 exc_cause", 32'(exc_cause), 32'(e.cause));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        chk("R1 cfg_q", 32'(cfg_q), 0);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 exc_valid", 32'(exc_valid), 0);
        chk("R1 xchk_valid", 32'(xchk_valid), 0);
        rst_n = 1'b1;
        idle(1);

        rs_set[2] = 1'b1; rs_set[6] = 1'b1;
        ws_set[5] = 1'b1; ws_set[6] = 1'b1;

        // R2/R3: nothing enabled, hits ignored
        snoop(8'h02, 1'b1); snoop(8'h05, 1'b0); idle(3);

        // R2/R4: exclusive read-set only; shared ignored, exclusive conflicts
        wcfg(5'b00010);
        snoop(8'h02, 1'b0); idle(3);
        snoop(8'h02, 1'b1); idle(3);
        chk("R6 enables cleared", 32'(cfg_q), 0);

        // R4: shared read-set
        wcfg(5'b00001); snoop(8'h02, 1'b0); idle(3);

        // R5: write-set conflicts with nack mode clear
        wcfg(5'b01100); snoop(8'h05, 1'b0); idle(3);
        wcfg(5'b01100); snoop(8'h05, 1'b1); idle(3);

        // R5: nack mode, both request types, no exception, config kept
        wcfg(5'b11100); snoop(8'h05, 1'b0); snoop(8'h05, 1'b1); idle(3);
        chk("R5 cfg unchanged after nack", 32'(cfg_q), 5'b11100);

        // R2: nack mode alone looks nothing up
        wcfg(5'b10000); snoop(8'h05, 1'b1); idle(3);

        // R6: back-to-back, second snoop sees lookups disabled, nack bit kept
        wcfg(5'b11010); snoop(8'h02, 1'b1); snoop(8'h02, 1'b1); idle(3);
        chk("R6 nack bit kept", 32'(cfg_q), 5'b10000);

        // R7: read-set ahead of write-set on the same snoop
        wcfg(5'b01010); snoop(8'h06, 1'b1); idle(3);

        // R8: timeout cases
        tmo_case(4'd3, 1'b1);
        tmo_case(4'd15, 1'b1);
        tmo_case(4'd0, 1'b0);
        tmo_limit = 4'd3;
        fx_rsp_valid = 1'b1; fx_rsp_nack = 1'b1; idle(1);
        fx_rsp_nack = 1'b0; idle(1);
        fx_rsp_valid = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R8 cancelled by non-nack reply", 32'(exc_valid), 0);
        end

        // R7: conflict and timeout in the same cycle, retry follows
        wcfg(5'b00010);
        fx_rsp_valid = 1'b1; fx_rsp_nack = 1'b1;
        @(negedge clk);
        fx_rsp_valid = 1'b0; fx_rsp_nack = 1'b0;
        idle(2);
        snoop(8'h02, 1'b1);
        @(negedge clk);
        @(negedge clk);
        chk("R7 deferred retry", 32'(exc_valid), 1);
        chk("R7 deferred retry cause", 32'(exc_cause), 4);
        idle(2);

        // R9: sibling cross-check
        loc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R9 store to owned line");
        loc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9 load, no copy phase");
        loc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R9 load during copy phase");
        loc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9 store to unowned line");

        idle(2);
        chk("R3 all responses seen", 32'(q.size()), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule